// File: doc/BRIEF.md
# 8-bit ALU with Flag Byte

This block is the arithmetic, logic and shift unit of a small 8-bit datapath. A 4-bit operation code selects one of sixteen functions. The function acts on an accumulator operand and a second operand. It produces a combinational result and a candidate flag byte. The candidate byte is computed from the operands and from the flag byte the block currently holds.

The flag byte is held in an internal register. When the write-enable is high, the candidate byte is loaded on the next rising clock edge. When the write-enable is low, the register keeps its value. The carry held in this register feeds the carry-using operations: add-with-carry, subtract-with-borrow, the rotates through carry, and the two carry-flag operations. Branch logic outside the block reads the sign, zero, parity/overflow and carry bits straight from the registered flag output.

Top module: `alu8_core`

## Requirements
- R1: The flag byte has carry C at bit 0, add/subtract N at bit 1, parity/overflow PV at bit 2, half-carry H at bit 4, zero Z at bit 6 and sign S at bit 7. Bits 3 and 5 always read 0. After reset the flag byte is 0x00.
- R2: The flag register loads `flags_nxt_o` on a rising edge where `wr_en_i` is 1. When `wr_en_i` is 0 it holds its value, whatever the operation or operands are.
- R3: Codes 0 (add) and 1 (add with carry in C) give `res_o` = (a + b + cin) mod 256. They set C on a carry out of bit 7, H on a carry out of bit 3, and PV on signed overflow outside -128..+127. They clear N.
- R4: Codes 2 (subtract) and 3 (subtract with borrow in C) give `res_o` = (a - b - cin) mod 256. They set C when a borrow is needed, H on a borrow from bit 4, and PV on signed overflow. They set N to 1.
- R5: Codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result. They clear C, H and N, and set PV to 1 when the result holds an even number of one bits.
- R6: For every code except 14 and 15, S copies result bit 7 and Z is 1 exactly when the result is 0x00.
- R7: Code 7 rotates left through carry: old C enters bit 0 and bit 7 goes to C. Code 8 rotates right through carry: old C enters bit 7 and bit 0 goes to C.
- R8: Code 9 rotates left circularly and code 11 shifts left with a 0 fill; both load C from old bit 7. Code 10 rotates right circularly, code 12 shifts right keeping bit 7, and code 13 shifts right with a 0 fill; all three load C from old bit 0.
- R9: Code 14 forces C to 1 and code 15 inverts C. Both clear H and N, keep S, Z and PV, and pass operand a to `res_o`.
- R10: Codes 7 through 13 clear H and N, and set PV to the even parity of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| wr_en_i | input | 1 | Flag register load enable |
| res_o | output | 8 | Combinational result |
| flags_nxt_o | output | 8 | Candidate flag byte for the current operation |
| flags_o | output | 8 | Registered flag byte |

## Verification
Every operation code is tried with all 256 accumulator values. Each is paired with sixteen second operands spaced by 0x11, so the mix holds 0x00, 0xFF, 0x77 and 0x88. This pairs operands with equal and unequal signs and nibbles on both sides of the half-carry boundary, which separates true signed overflow from plain carry. The same sweep runs once with the held carry at 0 and once at 1. This shows the carry-in of the with-carry arithmetic and the carry link of the rotates, and it shows that the plain add and subtract ignore the carry. Clocked steps with the enable low, and then high, separate holding the flag byte from loading it.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_RLT = 4'd7,
    OP_RRT = 4'd8,  OP_RLC = 4'd9,  OP_RRC = 4'd10, OP_SLA = 4'd11,
    OP_SRA = 4'd12, OP_SRL = 4'd13, OP_SCF = 4'd14, OP_CCF = 4'd15
  } alu_op_e;

  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_H  = 4;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  // Assemble the flag byte; spare bits 3 and 5 stay zero.
  function automatic logic [7:0] pack_flags(input logic s, input logic z,
                                            input logic h, input logic pv,
                                            input logic n, input logic c);
    logic [7:0] f;
    f        = 8'h00;
    f[FB_S]  = s;
    f[FB_Z]  = z;
    f[FB_H]  = h;
    f[FB_PV] = pv;
    f[FB_N]  = n;
    f[FB_C]  = c;
    return f;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hc_o,
  output logic         ov_o
);
  localparam int H = W / 2;

  logic [W-1:0] b_x;
  logic         c_x;
  logic [W:0]   full;
  logic [H:0]   low;

  // Subtraction is a + ~b + ~cin; borrow is the inverted carry.
  always_comb begin
    b_x   = sub_i ? ~b_i : b_i;
    c_x   = sub_i ^ cin_i;
    full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, c_x};
    low   = {1'b0, a_i[H-1:0]} + {1'b0, b_x[H-1:0]} + {{H{1'b0}}, c_x};
    sum_o = full[W-1:0];
    cy_o  = full[W] ^ sub_i;
    hc_o  = low[H] ^ sub_i;
    ov_o  = (a_i[W-1] == b_x[W-1]) && (full[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
  parameter int W = 8
) (
  input  alu8_pkg::alu_op_e op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic [W-1:0]      res_o
);
  import alu8_pkg::*;

  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu8_rotshift.sv
module alu8_rotshift #(
  parameter int W = 8
) (
  input  alu8_pkg::alu_op_e op_i,
  input  logic [W-1:0]      a_i,
  input  logic              cin_i,
  output logic [W-1:0]      res_o,
  output logic              cy_o
);
  import alu8_pkg::*;

  logic msb, lsb;
  assign msb = a_i[W-1];
  assign lsb = a_i[0];

  always_comb begin
    case (op_i)
      OP_RLT:  begin res_o = {a_i[W-2:0], cin_i}; cy_o = msb; end
      OP_RRT:  begin res_o = {cin_i, a_i[W-1:1]}; cy_o = lsb; end
      OP_RLC:  begin res_o = {a_i[W-2:0], msb};   cy_o = msb; end
      OP_RRC:  begin res_o = {lsb, a_i[W-1:1]};   cy_o = lsb; end
      OP_SLA:  begin res_o = {a_i[W-2:0], 1'b0};  cy_o = msb; end
      OP_SRA:  begin res_o = {msb, a_i[W-1:1]};   cy_o = lsb; end
      default: begin res_o = {1'b0, a_i[W-1:1]};  cy_o = lsb; end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              wr_en_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        flags_nxt_o,
  output logic [7:0]        flags_o
);
  import alu8_pkg::*;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // Named class decodes, also watched by the checker.
  logic is_arith, is_sub, is_logic, is_shift, is_cflag;
  assign is_arith = (op_i <= 4'd3);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_shift = (op_i >= 4'd7) && (op_i <= 4'd13);
  assign is_cflag = (op == OP_SCF) || (op == OP_CCF);

  logic [7:0] flags_q;
  logic       c_cur;
  assign c_cur = flags_q[FB_C];

  logic              use_cin;
  logic [DATA_W-1:0] as_sum, lg_res, rs_res;
  logic              as_cy, as_hc, as_ov, rs_cy;

  assign use_cin = (op == OP_ADC) || (op == OP_SBC);

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .cin_i(use_cin & c_cur), .sub_i(is_sub),
    .sum_o(as_sum), .cy_o(as_cy), .hc_o(as_hc), .ov_o(as_ov)
  );

  alu8_bitwise #(.W(DATA_W)) u_bitwise (
    .op_i(op), .a_i(a_i), .b_i(b_i), .res_o(lg_res)
  );

  alu8_rotshift #(.W(DATA_W)) u_rotshift (
    .op_i(op), .a_i(a_i), .cin_i(c_cur), .res_o(rs_res), .cy_o(rs_cy)
  );

  logic res_s, res_z, res_par;
  assign res_s   = res_o[DATA_W-1];
  assign res_z   = (res_o == '0);
  assign res_par = ~^res_o;

  always_comb begin
    if (is_arith) begin
      res_o       = as_sum;
      flags_nxt_o = pack_flags(res_s, res_z, as_hc, as_ov, is_sub, as_cy);
    end else if (is_logic) begin
      res_o       = lg_res;
      flags_nxt_o = pack_flags(res_s, res_z, 1'b0, res_par, 1'b0, 1'b0);
    end else if (is_shift) begin
      res_o       = rs_res;
      flags_nxt_o = pack_flags(res_s, res_z, 1'b0, res_par, 1'b0, rs_cy);
    end else begin
      res_o       = a_i;
      flags_nxt_o = pack_flags(flags_q[FB_S], flags_q[FB_Z], 1'b0,
                               flags_q[FB_PV], 1'b0,
                               (op == OP_SCF) ? 1'b1 : ~c_cur);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= 8'h00;
    else if (wr_en_i) flags_q <= flags_nxt_o;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] res_o,
  input logic [7:0]        flags_nxt_o,
  input logic [7:0]        flags_o,
  input logic              is_sub,
  input logic              is_logic,
  input logic              is_cflag
);
  import alu8_pkg::*;

  a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[3] == 1'b0) && (flags_o[5] == 1'b0));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(flags_o));

  a_r2_load_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (flags_o == $past(flags_nxt_o)));

  a_r4_sub_sets_n: assert property (@(posedge clk) disable iff (!rst_n)
    is_sub |-> flags_nxt_o[FB_N]);

  a_r5_logic_clears_c: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |-> !flags_nxt_o[FB_C]);

  a_r6_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cflag |-> (flags_nxt_o[FB_Z] == (res_o == '0)));

  a_r9_scf_forces_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd14) |-> flags_nxt_o[FB_C]);

  a_r9_ccf_inverts_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd15) |-> (flags_nxt_o[FB_C] != flags_o[FB_C]));
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .wr_en_i(wr_en_i),
  .res_o(res_o), .flags_nxt_o(flags_nxt_o), .flags_o(flags_o),
  .is_sub(is_sub), .is_logic(is_logic), .is_cflag(is_cflag)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] a_i = 8'h00;
  logic [7:0] b_i = 8'h00;
  logic       wr_en_i = 1'b0;
  logic [7:0] res_o, flags_nxt_o, flags_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int model_flags = 0;

  always #2 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .wr_en_i(wr_en_i), .res_o(res_o), .flags_nxt_o(flags_nxt_o),
    .flags_o(flags_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int sgn8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int even_par(input int v);
    int k = 0;
    for (int i = 0; i < 8; i++) k += (v >> i) & 1;
    return (k % 2 == 0) ? 1 : 0;
  endfunction

  function automatic string req_of(input int op);
    if (op <= 1) return "R3,R6";
    if (op <= 3) return "R4,R6";
    if (op <= 6) return "R5,R6";
    if (op <= 8) return "R7,R10";
    if (op <= 13) return "R8,R10";
    return "R9";
  endfunction

  // Independent arithmetic model of result and next flag byte.
  task automatic model(input int op, input int a, input int b, input int fl,
                       output int res, output int nf);
    int c, cy, h, pv, n, s;
    c = fl & 1; cy = 0; h = 0; pv = 0; n = 0;
    case (op)
      0, 1: begin
        int ci = (op == 1) ? c : 0;
        int t  = a + b + ci;
        int st = sgn8(a) + sgn8(b) + ci;
        res = t % 256; cy = (t > 255);
        h = ((a % 16) + (b % 16) + ci) > 15;
        pv = (st > 127) || (st < -128);
      end
      2, 3: begin
        int ci = (op == 3) ? c : 0;
        int t  = a - b - ci;
        int st = sgn8(a) - sgn8(b) - ci;
        res = (t + 512) % 256; cy = (t < 0);
        h = ((a % 16) - (b % 16) - ci) < 0;
        pv = (st > 127) || (st < -128); n = 1;
      end
      4: res = a & b;
      5: res = a | b;
      6: res = a ^ b;
      7:  begin res = (a * 2 + c) % 256;             cy = a / 128; end
      8:  begin res = a / 2 + c * 128;               cy = a % 2;   end
      9:  begin res = (a * 2 + a / 128) % 256;       cy = a / 128; end
      10: begin res = a / 2 + (a % 2) * 128;        cy = a % 2;   end
      11: begin res = (a * 2) % 256;                 cy = a / 128; end
      12: begin res = a / 2 + (a / 128) * 128;      cy = a % 2;   end
      13: begin res = a / 2;                         cy = a % 2;   end
      default: res = a;
    endcase
    if (op >= 4 && op <= 13) pv = even_par(res);
    if (op >= 14) begin
      nf = (fl & 8'hC4) | ((op == 14) ? 1 : (1 - c));
    end else begin
      s = res / 128;
      nf = s * 128 + ((res == 0) ? 64 : 0) + h * 16 + pv * 4 + n * 2 + cy;
    end
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Clocked write of one operation into the flag register.
  task automatic step_write(input int op, input int a, input int b);
    int r, nf;
    @(negedge clk);
    op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0]; wr_en_i = 1'b1;
    model(op, a, b, model_flags, r, nf);
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    check("R2", flags_o, nf, "flag load with enable");
    model_flags = nf;
  endtask

  task automatic sweep(input string tag);
    int r, nf;
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++) begin
          op_i = op[3:0]; a_i = a[7:0]; b_i = 8'(k * 17);
          #1;
          model(op, a, k * 17, model_flags, r, nf);
          total = total + 1;
          if (res_o != r[7:0] || flags_nxt_o != nf[7:0]) begin
            bad = bad + 1;
            $display("FAIL %s %s op=%0d a=%02h b=%02h: actual res=%02h flags=%02h expected res=%02h flags=%02h",
                     req_of(op), tag, op, a, k * 17, res_o, flags_nxt_o, r, nf);
          end
        end
  endtask

  initial begin
    #1;
    check("R1", flags_o, 8'h00, "flags during reset");
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", flags_o, 8'h00, "flags after reset");

    // Carry clear: AND gives 0x44 (Z and even parity).
    step_write(4, 0, 0);
    check("R1", flags_o & 8'h28, 0, "spare bits 3 and 5");
    sweep("carry=0");

    // R2 hold: enable low while presenting a flag-changing op.
    @(negedge clk);
    op_i = 4'd14; a_i = 8'h5A; wr_en_i = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R2", flags_o, model_flags, "hold with enable low");

    // Carry set via SCF, then sweep again.
    step_write(14, 8'h33, 0);
    check("R9", flags_o & 1, 1, "SCF carry");
    sweep("carry=1");

    // CCF toggles the held carry twice.
    step_write(15, 0, 0);
    check("R9", flags_o & 1, 0, "CCF carry from 1");
    step_write(15, 0, 0);
    check("R9", flags_o & 1, 1, "CCF carry from 0");

    // Overflow corner: 0x7F + 0x01 and 0x80 - 0x01.
    step_write(0, 8'h7F, 8'h01);
    check("R3", flags_o, 8'h94, "7F+01 flags");
    step_write(2, 8'h80, 8'h01);
    check("R4", flags_o, 8'h16, "80-01 flags");
    step_write(13, 8'hFF, 0);
    check("R8", flags_o, 8'h01, "SRL FF flags");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule